// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central hazard tracker for a machine with several functional units that are not pipelined. Each cycle it may accept one decoded instruction, given as a unit class, a destination register, two source registers and a tag. Instructions issue in program order to a free unit of the right class. Each unit then waits until both of its sources have been written, reads them together, counts down its execution latency, and writes its result once no earlier reader still needs the old value of the destination. The register file, the arithmetic and any forwarding path stay outside the block. The block only produces the control strobes and a per-unit trace.

Each unit runs its own state machine with four states: `ST_IDLE` (free), `ST_READ` (issued, waiting for operands), `ST_EXEC` (counting down) and `ST_WRITE` (finished, waiting to write back). The transitions are:

- **issue**: `ST_IDLE` to `ST_READ`.
- **operand grant**: `ST_READ` to `ST_EXEC`.
- **count expiry**: `ST_EXEC` to `ST_WRITE`.
- **write grant**: `ST_WRITE` to `ST_IDLE`.

A register result table records which unit will write each register. An issue stage picks the lowest-numbered idle unit of the requested class. The default unit mix is:

| Unit index | Class |
|---|---|
| 0 | integer/load |
| 1 and 2 | multiply |
| 3 | add |
| 4 | divide |

Top module: `scoreboard_ctrl`

## Requirements
- R1: After synchronous active-high reset, every unit reports state 0 (idle), `rd_grant` and `wb_grant` are all zero, and `issue_stall` is low while `in_valid` is low.
- R2: Issue is in program order. An instruction is accepted in a cycle where `in_valid` is high and `issue_stall` is low, with `issue_fire` high in that cycle. A stalled instruction blocks all later ones. The chosen unit is the lowest-indexed idle unit of the class, where class code 0 means integer (unit 0), 2 means multiply (units 1, 2), 1 means add (unit 3) and 3 means divide (unit 4).
- R3: An instruction whose destination register already has a pending writer stalls at issue until that writer's write-back cycle has passed.
- R4: An instruction stalls at issue while no unit of its class is idle.
- R5: A unit issued in cycle t enters the read state in cycle t+1. It asserts `rd_grant` in the first cycle in which both sources have no earlier pending writer, reading both together. There is no forwarding: a reader of a value written back in cycle w gets its grant in cycle w+1 at the earliest.
- R6: After the `rd_grant` cycle, a unit spends exactly max(latency,1) cycles in the execute state and then enters the write state. The latencies are integer 0, add 2, multiply 10 and divide 40.
- R7: A unit in the write state withholds `wb_grant` while another unit in the read state still holds an unread source equal to its destination register.
- R8: A `wb_grant` in cycle w returns the unit to idle in cycle w+1, clears its register table entry, and marks waiting operands ready. A new issue to that unit or that destination register is possible from cycle w+1.
- R9: `unit_state` gives each unit's state in two bits (0 idle, 1 read, 2 execute, 3 write) at bit position 2u. `unit_tag` gives the tag of the instruction held by unit u at bit position 4u.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_class | input | 2 | Unit class code |
| in_dst | input | 5 | Destination register |
| in_src1 | input | 5 | First source register |
| in_src2 | input | 5 | Second source register |
| in_tag | input | 4 | Instruction tag carried into the trace |
| issue_stall | output | 1 | Presented instruction cannot issue this cycle |
| issue_fire | output | 1 | Presented instruction issues this cycle |
| issue_unit | output | 3 | Unit index receiving the issue |
| rd_grant | output | 5 | Per-unit operand read strobe |
| wb_grant | output | 5 | Per-unit result write strobe |
| unit_state | output | 10 | Per-unit state trace, 2 bits each |
| unit_tag | output | 20 | Per-unit instruction tag, 4 bits each |

## Verification
A wrong register table entry or a stale ready flag shows up as a missed or early `rd_grant`, or as an issue that should have stalled. This is visible at the ports within a cycle or two of the producer's write-back. A wrong WAR decision moves `wb_grant` away from the cycle after the blocking reader's grant. A wrong latency count shifts every later read and write strobe of the dependent chain by the same number of cycles. The bench therefore compares the exact cycle and tag of every issue, read and write event against a hand-derived timeline for two instruction sequences.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_EXEC  = 2'd2,
        ST_WRITE = 2'd3
    } ustate_e;

    localparam logic [1:0] CL_INT = 2'd0;
    localparam logic [1:0] CL_ADD = 2'd1;
    localparam logic [1:0] CL_MUL = 2'd2;
    localparam logic [1:0] CL_DIV = 2'd3;

    // Units are laid out integer first, then multiply, add, divide.
    function automatic logic [1:0] class_of(input int idx, input int n_int,
                                            input int n_mul, input int n_add);
        if (idx < n_int)                    return CL_INT;
        else if (idx < n_int + n_mul)       return CL_MUL;
        else if (idx < n_int + n_mul + n_add) return CL_ADD;
        else                                return CL_DIV;
    endfunction

endpackage

// File: rtl/sb_unit.sv
module sb_unit
    import sb_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int UID_W    = 3,
    parameter int TAG_W    = 4,
    parameter int NU       = 5,
    parameter int EXEC_CYC = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_en,
    input  logic [REG_W-1:0] iss_dst,
    input  logic [REG_W-1:0] iss_src1,
    input  logic [REG_W-1:0] iss_src2,
    input  logic [UID_W-1:0] iss_q1,
    input  logic [UID_W-1:0] iss_q2,
    input  logic             iss_r1,
    input  logic             iss_r2,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic [NU-1:0]    wb_bcast,
    input  logic             war_clear,
    output ustate_e          state_o,
    output logic [REG_W-1:0] dst_o,
    output logic [REG_W-1:0] src1_o,
    output logic [REG_W-1:0] src2_o,
    output logic             r1_o,
    output logic             r2_o,
    output logic [TAG_W-1:0] tag_o,
    output logic             rd_go,
    output logic             wb_go
);

    localparam int CNT_W = (EXEC_CYC > 1) ? $clog2(EXEC_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(EXEC_CYC - 1);

    ustate_e          state, state_n;
    logic [REG_W-1:0] dst, src1, src2;
    logic [UID_W-1:0] q1, q2;
    logic             r1, r2;
    logic [CNT_W-1:0] cnt;
    logic [TAG_W-1:0] tag;
    logic             hit1, hit2;

    // Does the producer named in Qj / Qk write back this cycle?
    always_comb begin
        hit1 = 1'b0;
        hit2 = 1'b0;
        for (int i = 0; i < NU; i++) begin
            if (q1 == UID_W'(i) && wb_bcast[i]) hit1 = 1'b1;
            if (q2 == UID_W'(i) && wb_bcast[i]) hit2 = 1'b1;
        end
    end

    // Output process
    always_comb begin
        rd_go = (state == ST_READ) && r1 && r2;
        wb_go = (state == ST_WRITE) && war_clear;
    end

    // Next-state process
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (issue_en)   state_n = ST_READ;
            ST_READ:  if (rd_go)      state_n = ST_EXEC;
            ST_EXEC:  if (cnt == '0)  state_n = ST_WRITE;
            ST_WRITE: if (wb_go)      state_n = ST_IDLE;
            default:                  state_n = ST_IDLE;
        endcase
    end

    // State register and status fields
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            dst   <= '0;
            src1  <= '0;
            src2  <= '0;
            q1    <= '0;
            q2    <= '0;
            r1    <= 1'b0;
            r2    <= 1'b0;
            cnt   <= '0;
            tag   <= '0;
        end else begin
            state <= state_n;
            unique case (state)
                ST_IDLE: begin
                    if (issue_en) begin
                        dst  <= iss_dst;
                        src1 <= iss_src1;
                        src2 <= iss_src2;
                        q1   <= iss_q1;
                        q2   <= iss_q2;
                        r1   <= iss_r1;
                        r2   <= iss_r2;
                        tag  <= iss_tag;
                    end
                end
                ST_READ: begin
                    if (rd_go) begin
                        r1  <= 1'b0;
                        r2  <= 1'b0;
                        q1  <= '0;
                        q2  <= '0;
                        cnt <= CNT_LOAD;
                    end else begin
                        if (!r1 && hit1) begin
                            r1 <= 1'b1;
                            q1 <= '0;
                        end
                        if (!r2 && hit2) begin
                            r2 <= 1'b1;
                            q2 <= '0;
                        end
                    end
                end
                ST_EXEC: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                end
                ST_WRITE: begin
                    cnt <= '0;
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end

    assign state_o = state;
    assign dst_o   = dst;
    assign src1_o  = src1;
    assign src2_o  = src2;
    assign r1_o    = r1;
    assign r2_o    = r2;
    assign tag_o   = tag;

    // R5: an operand grant always moves the unit into execution
    a_r5_read_to_exec: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> (state == ST_EXEC));

    // R8: a write grant frees the unit on the next cycle
    a_r8_write_frees: assert property (@(posedge clk) disable iff (rst)
        wb_go |=> (state == ST_IDLE));

    // R6: the write state is only entered from a finished countdown
    a_r6_write_after_exec: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && cnt != '0) |=> (state == ST_EXEC));

endmodule

// File: rtl/sb_regtab.sv
module sb_regtab #(
    parameter int NREG  = 32,
    parameter int REG_W = 5,
    parameter int NU    = 5,
    parameter int UID_W = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_en,
    input  logic [REG_W-1:0]      set_reg,
    input  logic [UID_W-1:0]      set_uid,
    input  logic [NU-1:0]         wb_vec,
    output logic [NREG-1:0]       pend,
    output logic [NREG*UID_W-1:0] owner_flat
);

    logic [UID_W-1:0] owner [NREG];
    logic [NREG-1:0]  clr;

    always_comb begin
        clr = '0;
        for (int r = 0; r < NREG; r++) begin
            for (int u = 0; u < NU; u++) begin
                if (pend[r] && owner[r] == UID_W'(u) && wb_vec[u]) clr[r] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            for (int r = 0; r < NREG; r++) owner[r] <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (set_en && set_reg == REG_W'(r)) begin
                    pend[r]  <= 1'b1;
                    owner[r] <= set_uid;
                end else if (clr[r]) begin
                    pend[r]  <= 1'b0;
                    owner[r] <= '0;
                end
            end
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_flat
        assign owner_flat[r*UID_W +: UID_W] = owner[r];
    end

    // R3: issue never claims a register that already has a pending writer
    a_r3_no_double_claim: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !pend[set_reg]);

    // R8: a unit owns at most one register entry at any time
    for (genvar u = 0; u < NU; u++) begin : g_claim
        logic [NREG-1:0] claims;
        always_comb begin
            for (int r = 0; r < NREG; r++)
                claims[r] = pend[r] && (owner[r] == UID_W'(u));
        end
        a_r8_single_claim: assert property (@(posedge clk) disable iff (rst)
            $countones(claims) <= 1);
    end

endmodule

// File: rtl/sb_issue.sv
module sb_issue
    import sb_pkg::*;
#(
    parameter int NU    = 5,
    parameter int UID_W = 3,
    parameter int N_INT = 1,
    parameter int N_MUL = 2,
    parameter int N_ADD = 1
) (
    input  logic             in_valid,
    input  logic [1:0]       in_class,
    input  logic [NU-1:0]    unit_idle,
    input  logic             dst_busy,
    output logic             fire,
    output logic             stall,
    output logic [UID_W-1:0] sel_uid,
    output logic [NU-1:0]    sel_vec
);

    logic [NU-1:0] cand;
    logic          found;

    for (genvar i = 0; i < NU; i++) begin : g_cand
        localparam logic [1:0] CLS = class_of(i, N_INT, N_MUL, N_ADD);
        assign cand[i] = unit_idle[i] && (in_class == CLS);
    end

    // Lowest-indexed idle unit of the class wins
    always_comb begin
        sel_uid = '0;
        found   = 1'b0;
        for (int i = NU - 1; i >= 0; i--) begin
            if (cand[i]) begin
                sel_uid = UID_W'(i);
                found   = 1'b1;
            end
        end
        fire  = in_valid && found && !dst_busy;
        stall = in_valid && !fire;
        sel_vec = '0;
        for (int i = 0; i < NU; i++) begin
            if (fire && sel_uid == UID_W'(i)) sel_vec[i] = 1'b1;
        end
    end

endmodule

// File: rtl/scoreboard_ctrl.sv
module scoreboard_ctrl
    import sb_pkg::*;
#(
    parameter int NREG    = 32,
    parameter int TAG_W   = 4,
    parameter int N_INT   = 1,
    parameter int N_MUL   = 2,
    parameter int N_ADD   = 1,
    parameter int N_DIV   = 1,
    parameter int LAT_INT = 0,
    parameter int LAT_ADD = 2,
    parameter int LAT_MUL = 10,
    parameter int LAT_DIV = 40,
    localparam int NU     = N_INT + N_MUL + N_ADD + N_DIV,
    localparam int UID_W  = (NU > 1) ? $clog2(NU) : 1,
    localparam int REG_W  = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [1:0]          in_class,
    input  logic [REG_W-1:0]    in_dst,
    input  logic [REG_W-1:0]    in_src1,
    input  logic [REG_W-1:0]    in_src2,
    input  logic [TAG_W-1:0]    in_tag,
    output logic                issue_stall,
    output logic                issue_fire,
    output logic [UID_W-1:0]    issue_unit,
    output logic [NU-1:0]       rd_grant,
    output logic [NU-1:0]       wb_grant,
    output logic [2*NU-1:0]     unit_state,
    output logic [TAG_W*NU-1:0] unit_tag
);

    ustate_e          ust  [NU];
    logic [REG_W-1:0] udst [NU];
    logic [REG_W-1:0] us1  [NU];
    logic [REG_W-1:0] us2  [NU];
    logic [NU-1:0]    ur1, ur2, idle_vec, sel_vec, war_block;

    logic [NREG-1:0]       pend;
    logic [NREG*UID_W-1:0] owner_flat;
    logic [UID_W-1:0]      owner [NREG];
    logic                  src_rdy1, src_rdy2, bypass1, bypass2;

    for (genvar r = 0; r < NREG; r++) begin : g_own
        assign owner[r] = owner_flat[r*UID_W +: UID_W];
    end

    sb_regtab #(.NREG(NREG), .REG_W(REG_W), .NU(NU), .UID_W(UID_W)) u_regtab (
        .clk       (clk),
        .rst       (rst),
        .set_en    (issue_fire),
        .set_reg   (in_dst),
        .set_uid   (issue_unit),
        .wb_vec    (wb_grant),
        .pend      (pend),
        .owner_flat(owner_flat)
    );

    sb_issue #(.NU(NU), .UID_W(UID_W), .N_INT(N_INT), .N_MUL(N_MUL),
               .N_ADD(N_ADD)) u_issue (
        .in_valid (in_valid),
        .in_class (in_class),
        .unit_idle(idle_vec),
        .dst_busy (pend[in_dst]),
        .fire     (issue_fire),
        .stall    (issue_stall),
        .sel_uid  (issue_unit),
        .sel_vec  (sel_vec)
    );

    // A source is ready when nobody owns it, or its owner writes it back
    // in the very cycle of issue (that owner will not broadcast again).
    always_comb begin
        bypass1 = 1'b0;
        bypass2 = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (owner[in_src1] == UID_W'(u) && wb_grant[u]) bypass1 = 1'b1;
            if (owner[in_src2] == UID_W'(u) && wb_grant[u]) bypass2 = 1'b1;
        end
        src_rdy1 = !pend[in_src1] || bypass1;
        src_rdy2 = !pend[in_src2] || bypass2;
    end

    // WAR: hold write-back while an earlier reader still waits on the old value
    always_comb begin
        war_block = '0;
        for (int u = 0; u < NU; u++) begin
            for (int f = 0; f < NU; f++) begin
                if (f != u && ust[f] == ST_READ &&
                    ((ur1[f] && us1[f] == udst[u]) || (ur2[f] && us2[f] == udst[u])))
                    war_block[u] = 1'b1;
            end
        end
    end

    for (genvar gi = 0; gi < NU; gi++) begin : g_unit
        localparam logic [1:0] CLS = class_of(gi, N_INT, N_MUL, N_ADD);
        localparam int LAT = (CLS == CL_INT) ? LAT_INT :
                             (CLS == CL_ADD) ? LAT_ADD :
                             (CLS == CL_MUL) ? LAT_MUL : LAT_DIV;
        localparam int ECYC = (LAT < 1) ? 1 : LAT;

        sb_unit #(.REG_W(REG_W), .UID_W(UID_W), .TAG_W(TAG_W), .NU(NU),
                  .EXEC_CYC(ECYC)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .issue_en (sel_vec[gi]),
            .iss_dst  (in_dst),
            .iss_src1 (in_src1),
            .iss_src2 (in_src2),
            .iss_q1   (owner[in_src1]),
            .iss_q2   (owner[in_src2]),
            .iss_r1   (src_rdy1),
            .iss_r2   (src_rdy2),
            .iss_tag  (in_tag),
            .wb_bcast (wb_grant),
            .war_clear(!war_block[gi]),
            .state_o  (ust[gi]),
            .dst_o    (udst[gi]),
            .src1_o   (us1[gi]),
            .src2_o   (us2[gi]),
            .r1_o     (ur1[gi]),
            .r2_o     (ur2[gi]),
            .tag_o    (unit_tag[gi*TAG_W +: TAG_W]),
            .rd_go    (rd_grant[gi]),
            .wb_go    (wb_grant[gi])
        );

        assign idle_vec[gi]           = (ust[gi] == ST_IDLE);
        assign unit_state[2*gi +: 2]  = ust[gi];

        // R2: the unit named at issue is waiting for operands next cycle
        a_r2_issue_lands: assert property (@(posedge clk) disable iff (rst)
            (issue_fire && issue_unit == UID_W'(gi)) |=> (ust[gi] == ST_READ));

        // R7: a unit in the write state never coexists with its write grant
        // while a pending reader of its destination still holds a ready flag
        a_r7_war_hold: assert property (@(posedge clk) disable iff (rst)
            (ust[gi] == ST_WRITE && !wb_grant[gi]) |=> (ust[gi] == ST_WRITE));
    end

endmodule

// File: tb/tb_scoreboard_ctrl.sv
module tb_scoreboard_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = '0;
    logic [4:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic [3:0]  in_tag = '0;
    logic        issue_stall, issue_fire;
    logic [2:0]  issue_unit;
    logic [4:0]  rd_grant, wb_grant;
    logic [9:0]  unit_state;
    logic [19:0] unit_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    scoreboard_ctrl dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2), .in_tag(in_tag),
        .issue_stall(issue_stall), .issue_fire(issue_fire), .issue_unit(issue_unit),
        .rd_grant(rd_grant), .wb_grant(wb_grant), .unit_state(unit_state),
        .unit_tag(unit_tag)
    );

    typedef struct {int cyc; int tag; int kind;} ev_t;
    ev_t exp_q[$];

    int  n_cmp = 0, n_bad = 0;
    int  cyc = 0, base = 0, prog = 0;
    bit  mon_on = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // kind: 0 issue, 1 operand read, 2 write-back
    task automatic push(input int c, input int t, input int k);
        ev_t e;
        e.cyc = c; e.tag = t; e.kind = k;
        exp_q.push_back(e);
    endtask

    function automatic string req_of(input int k);
        if (k == 0) return "R2";
        if (k == 1) return "R5";
        return "R7";
    endfunction

    task automatic observe(input int rel, input int t, input int k);
        ev_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, req_of(k), "unexpected event cycle", rel, -1);
            return;
        end
        e = exp_q.pop_front();
        n_cmp++;
        if (e.cyc != rel || e.tag != t || e.kind != k) begin
            n_bad++;
            $display("FAIL %s event: actual cyc %0d tag %0d kind %0d expected cyc %0d tag %0d kind %0d",
                     req_of(e.kind), rel, t, k, e.cyc, e.tag, e.kind);
        end
    endtask

    // Monitor: pops expected events as the design produces them
    always @(negedge clk) begin
        if (mon_on) begin
            automatic int rel = cyc - base + 1;
            if (issue_fire) observe(rel, int'(in_tag), 0);
            for (int u = 0; u < 5; u++)
                if (rd_grant[u]) observe(rel, int'(unit_tag[4*u +: 4]), 1);
            for (int u = 0; u < 5; u++)
                if (wb_grant[u]) observe(rel, int'(unit_tag[4*u +: 4]), 2);
            if (prog == 1 && rel == 3) begin
                check(unit_state[1:0] == 2'd2, "R9", "integer unit executing", int'(unit_state[1:0]), 2);
                check(unit_tag[3:0] == 4'd0, "R9", "integer unit tag", int'(unit_tag[3:0]), 0);
            end
            if (prog == 1 && rel == 12)
                check(issue_stall == 1'b1, "R4", "add busy stall", int'(issue_stall), 1);
            if (prog == 1 && rel == 17)
                check(unit_state[7:6] == 2'd3, "R7", "add held in write", int'(unit_state[7:6]), 3);
            if (prog == 2 && rel == 10)
                check(issue_stall == 1'b1, "R3", "same-destination stall", int'(issue_stall), 1);
            if (prog == 2 && rel == 16) begin
                check(unit_state[9:8] == 2'd1, "R5", "divide waits for operand", int'(unit_state[9:8]), 1);
                check(unit_tag[19:16] == 4'd11, "R9", "divide tag", int'(unit_tag[19:16]), 11);
            end
        end
    end

    task automatic send(input int cls, input int d, input int s1, input int s2, input int t);
        in_valid = 1'b1;
        in_class = 2'(cls);
        in_dst   = 5'(d);
        in_src1  = 5'(s1);
        in_src2  = 5'(s2);
        in_tag   = 4'(t);
        forever begin
            @(negedge clk);
            if (!issue_stall) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (unit_state == '0 && exp_q.size() == 0) break;
        end
    endtask

    // Class codes: 0 integer, 1 add, 2 multiply, 3 divide
    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        check(issue_stall == 1'b0, "R1", "stall after reset", int'(issue_stall), 0);
        check(rd_grant == '0, "R1", "read grants after reset", int'(rd_grant), 0);
        check(wb_grant == '0, "R1", "write grants after reset", int'(wb_grant), 0);
        check(unit_state == '0, "R1", "unit states after reset", int'(unit_state), 0);

        // Program 1: two loads, multiply, subtract, divide, add with WAR on the last
        @(posedge clk);
        #1;
        prog = 1;
        base = cyc;
        push(1,0,0);  push(2,0,1);  push(4,0,2);  push(5,1,0);
        push(6,2,0);  push(6,1,1);  push(7,3,0);  push(8,4,0);
        push(8,1,2);  push(9,2,1);  push(9,3,1);  push(12,3,2);   // R6 add length
        push(13,5,0); push(14,5,1); push(20,2,2); push(21,4,1);   // R8 reuse after write
        push(22,5,2); push(62,4,2);                               // R6 divide length
        mon_on = 1'b1;
        send(0, 6, 2, 2, 0);
        send(0, 2, 3, 3, 1);
        send(2, 0, 2, 4, 2);
        send(1, 8, 6, 2, 3);
        send(3, 10, 0, 6, 4);
        send(1, 6, 8, 2, 5);
        drain();

        // Program 2: both multipliers, same-destination stall, in-order hold
        @(posedge clk);
        #1;
        prog = 2;
        base = cyc;
        push(1,8,0);  push(2,9,0);  push(2,8,1);  push(3,9,1);
        push(13,8,2); push(14,10,0); push(14,9,2); push(15,11,0);  // R3 R8
        push(15,10,1); push(18,10,2); push(19,11,1); push(60,11,2);
        send(2, 1, 2, 3, 8);
        send(2, 4, 5, 6, 9);
        send(1, 1, 7, 8, 10);
        send(3, 9, 4, 1, 11);
        drain();
        mon_on = 1'b0;

        check(exp_q.size() == 0, "R2", "events left unseen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 3000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule